// File: doc/BRIEF.md
# Standby Power Mode Sequencer

This block is the always-on controller that moves a chip out of full-speed operation into one of three reduced-power modes and brings it back. In the lightest mode only the processor clock is gated and the peripherals keep running. In the clock-halt mode every clock source stops, the PLL and oscillator included. In the deep mode the logic domain loses its supply altogether, so its state first has to be saved off-chip.

Software picks a mode and strobes a go input. The block then runs an ordered sequence of steps. Every step that depends on another agent (processor state save, cache/TLB flush, state scan out or in, power switch, clock source, processor state restore) starts with a one-cycle start pulse. The step ends when that agent's done or acknowledge signal arrives. If it does not arrive within a programmable limit, the sequence stops in an error state and a sticky flag is raised.

Either an interrupt or a real-time-clock match ends a low-power mode. A wake that arrives while an entry sequence is still running is remembered. The current step completes and the machine turns straight onto the return path.

Top module: `stbyModeSeq`

## Requirements
- R1: After reset, the status code is 0 (run). The processor clock, PLL enable and logic power enable are all 1, isolation is 0, the error flag is 0 and no start pulse is active.
- R2: Bit i of the per-IP clock enable output equals bit i of the per-IP mask input whenever the peripheral clocks are running, in the same cycle the mask changes. It is 0 for every bit while the clocks are halted or the power is off.
- R3: The light request (mode code 1) gates only the processor clock and shows status code 1. PLL, power and peripheral clocks stay on. A wake returns the block to status 0 with the processor clock on again.
- R4: The clock-halt request (mode code 2) turns off the processor clock, the peripheral clocks and the PLL. Power stays on, isolation stays off, and the status code is 2. On wake the block shows status 10 with only the PLL re-enabled. Once clock-ready is seen, all clocks return and the status goes back to 0.
- R5: The deep request (mode code 3) steps through these status codes in order: 4 (save start pulse), 5 (flush start pulse), 6 (clocks and PLL off, isolation on, scan-out start pulse), 7 (logic power off), and then 3 (suspended) once the power acknowledge reads 0.
- R6: A wake in status 3 steps through these codes in order: 8 (power on, isolation still on), 9 once the power acknowledge reads 1 (scan-in start pulse), 10 (PLL on, processor clock still off), 11 once clock-ready is seen (all clocks on, isolation off, restore start pulse), and 0 after restore done.
- R7: Either the interrupt wake or the timer-match wake ends a low-power mode. A wake while in status 0 is ignored and is not remembered for a later mode.
- R8: A wake during an entry step is held until that step's done arrives. A wake during save (4) or flush (5) then goes directly to 11. A wake during scan-out (6) goes directly to 10 with power still on. Power is never removed in either case.
- R9: If a step's handshake has not arrived by the cycle in which the step has lasted the step-limit count plus one, the block moves to status 15, sets the error flag and leaves every clock, power and isolation output unchanged.
- R10: The error flag stays set until the error-clear input is pulsed in status 15. That pulse returns the block to status 0 with all clocks and power on, isolation off and the flag cleared.
- R11: Isolation is on in every cycle in which logic power is off. It is released only in the same cycle that the processor clock and PLL are back on.
- R12: A go strobe with mode code 0 leaves the block in status 0 with every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeGo | input | 1 | Strobe that starts the requested mode |
| modeReq | input | 2 | Mode code: 0 run, 1 light, 2 clock-halt, 3 deep |
| ipClkMask | input | NUM_IP | Per-IP clock enable bits from software |
| irqWake | input | 1 | Interrupt wake event |
| rtcMatch | input | 1 | Real-time-clock match wake event |
| stepLimit | input | CNT_W | Step timeout limit in cycles |
| errClr | input | 1 | Clears the error state and flag |
| saveDone | input | 1 | Processor state save finished |
| flushDone | input | 1 | Cache and TLB flush finished |
| scanOutDone | input | 1 | State scan-out finished |
| pwrAck | input | 1 | Power switch status (1 = logic powered) |
| scanInDone | input | 1 | State scan-in finished |
| clkReady | input | 1 | Clock source stable |
| restoreDone | input | 1 | Processor state restore finished |
| ipClkEn | output | NUM_IP | Per-IP clock enables |
| cpuClkEn | output | 1 | Processor clock gate enable |
| pllEn | output | 1 | PLL and oscillator enable |
| logicPwrEn | output | 1 | Logic domain power switch enable |
| isoEn | output | 1 | Isolation/freeze of the logic domain outputs |
| saveStart | output | 1 | Start pulse for processor state save |
| flushStart | output | 1 | Start pulse for cache/TLB flush |
| scanOutStart | output | 1 | Start pulse for state scan-out |
| scanInStart | output | 1 | Start pulse for state scan-in |
| restoreStart | output | 1 | Start pulse for processor state restore |
| seqState | output | 4 | Status code of the sequencer |
| errFlag | output | 1 | Sticky step-timeout flag |

## Verification
Each clock, power and isolation output is a register loaded on the same edge on which the status code changes. Both therefore appear together one cycle after the handshake or wake that caused them. A start pulse is high only in the first cycle of its step. The per-IP enables follow the mask combinationally within the same cycle. The bench drives inputs and samples on the falling edge. It polls the status code until a step is first seen, so it reads each start pulse and output in the step's first cycle, and it counts falling edges exactly for the timeout window of R9. Handshake agents in the bench answer start pulses after a fixed delay, or they are switched off so the bench can hold, delay or withhold each done by hand.

// File: rtl/stbySeqPkg.sv
package stbySeqPkg;

  // Status codes; values are visible on seqState
  typedef enum logic [3:0] {
    ST_RUN     = 4'd0,
    ST_DOZE    = 4'd1,
    ST_HALTED  = 4'd2,
    ST_SUSP    = 4'd3,
    ST_SAVE    = 4'd4,
    ST_FLUSH   = 4'd5,
    ST_SCANOUT = 4'd6,
    ST_PWROFF  = 4'd7,
    ST_PWRON   = 4'd8,
    ST_SCANIN  = 4'd9,
    ST_CLKON   = 4'd10,
    ST_CPURST  = 4'd11,
    ST_ERR     = 4'd15
  } seqState_e;

  typedef enum logic [1:0] {
    MODE_RUN     = 2'd0,
    MODE_LIGHT   = 2'd1,
    MODE_CLKHALT = 2'd2,
    MODE_DEEP    = 2'd3
  } modeReq_e;

  // Strobes from the control FSM to the datapath registers
  typedef struct packed {
    logic cntClr;
    logic watchWake;
    logic cpuGate;
    logic cpuUngate;
    logic clkStop;
    logic pllOn;
    logic clkStart;
    logic isoSet;
    logic isoRelease;
    logic pwrCut;
    logic pwrRestore;
    logic deepSet;
    logic deepClr;
    logic errSet;
    logic errClr;
  } seqStrobe_t;

endpackage

// File: rtl/stbySeqCtrl.sv
module stbySeqCtrl
  import stbySeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeGo,
  input  logic [1:0] modeReq,
  input  logic       irqWake,
  input  logic       rtcMatch,
  input  logic       wakePend,
  input  logic       deepMode,
  input  logic       stepFirst,
  input  logic       timeoutHit,
  input  logic       errClr,
  input  logic       saveDone,
  input  logic       flushDone,
  input  logic       scanOutDone,
  input  logic       pwrAck,
  input  logic       scanInDone,
  input  logic       clkReady,
  input  logic       restoreDone,
  output seqState_e  state,
  output seqStrobe_t strobe,
  output logic       saveStart,
  output logic       flushStart,
  output logic       scanOutStart,
  output logic       scanInStart,
  output logic       restoreStart
);

  seqState_e  nxt;
  seqStrobe_t stb;
  logic       wakeAny;

  assign wakeAny = wakePend | irqWake | rtcMatch;

  always_comb begin
    nxt = state;
    stb = '0;
    unique case (state)
      ST_RUN: begin
        if (modeGo) begin
          unique case (modeReq_e'(modeReq))
            MODE_LIGHT: begin
              nxt = ST_DOZE;
              stb.cpuGate = 1'b1;
            end
            MODE_CLKHALT: begin
              nxt = ST_HALTED;
              stb.clkStop = 1'b1;
              stb.deepClr = 1'b1;
            end
            MODE_DEEP: begin
              nxt = ST_SAVE;
              stb.deepSet = 1'b1;
            end
            default: ;
          endcase
        end
      end
      ST_DOZE: begin
        if (wakeAny) begin
          nxt = ST_RUN;
          stb.cpuUngate = 1'b1;
        end
      end
      ST_HALTED: begin
        if (wakeAny) begin
          nxt = ST_CLKON;
          stb.pllOn = 1'b1;
        end
      end
      ST_SUSP: begin
        if (wakeAny) begin
          nxt = ST_PWRON;
          stb.pwrRestore = 1'b1;
        end
      end
      ST_SAVE: begin
        if (saveDone) begin
          nxt = wakeAny ? ST_CPURST : ST_FLUSH;
        end else if (timeoutHit) begin
          nxt = ST_ERR;
          stb.errSet = 1'b1;
        end
      end
      ST_FLUSH: begin
        if (flushDone) begin
          if (wakeAny) begin
            nxt = ST_CPURST;
          end else begin
            nxt = ST_SCANOUT;
            stb.clkStop = 1'b1;
            stb.isoSet = 1'b1;
          end
        end else if (timeoutHit) begin
          nxt = ST_ERR;
          stb.errSet = 1'b1;
        end
      end
      ST_SCANOUT: begin
        if (scanOutDone) begin
          if (wakeAny) begin
            nxt = ST_CLKON;
            stb.pllOn = 1'b1;
          end else begin
            nxt = ST_PWROFF;
            stb.pwrCut = 1'b1;
          end
        end else if (timeoutHit) begin
          nxt = ST_ERR;
          stb.errSet = 1'b1;
        end
      end
      ST_PWROFF: begin
        if (!pwrAck) begin
          if (wakeAny) begin
            nxt = ST_PWRON;
            stb.pwrRestore = 1'b1;
          end else begin
            nxt = ST_SUSP;
          end
        end else if (timeoutHit) begin
          nxt = ST_ERR;
          stb.errSet = 1'b1;
        end
      end
      ST_PWRON: begin
        if (pwrAck) begin
          nxt = ST_SCANIN;
        end else if (timeoutHit) begin
          nxt = ST_ERR;
          stb.errSet = 1'b1;
        end
      end
      ST_SCANIN: begin
        if (scanInDone) begin
          nxt = ST_CLKON;
          stb.pllOn = 1'b1;
        end else if (timeoutHit) begin
          nxt = ST_ERR;
          stb.errSet = 1'b1;
        end
      end
      ST_CLKON: begin
        if (clkReady) begin
          nxt = deepMode ? ST_CPURST : ST_RUN;
          stb.clkStart = 1'b1;
          stb.isoRelease = 1'b1;
        end else if (timeoutHit) begin
          nxt = ST_ERR;
          stb.errSet = 1'b1;
        end
      end
      ST_CPURST: begin
        if (restoreDone) begin
          nxt = ST_RUN;
          stb.deepClr = 1'b1;
        end else if (timeoutHit) begin
          nxt = ST_ERR;
          stb.errSet = 1'b1;
        end
      end
      ST_ERR: begin
        if (errClr) begin
          nxt = ST_RUN;
          stb.errClr = 1'b1;
          stb.pllOn = 1'b1;
          stb.clkStart = 1'b1;
          stb.pwrRestore = 1'b1;
          stb.isoRelease = 1'b1;
          stb.deepClr = 1'b1;
        end
      end
      default: begin
        nxt = ST_ERR;
        stb.errSet = 1'b1;
      end
    endcase
    stb.watchWake = (state == ST_SAVE) || (state == ST_FLUSH) ||
                    (state == ST_SCANOUT) || (state == ST_PWROFF);
    stb.cntClr = (nxt != state);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= nxt;
  end

  assign strobe       = stb;
  assign saveStart    = (state == ST_SAVE)    && stepFirst;
  assign flushStart   = (state == ST_FLUSH)   && stepFirst;
  assign scanOutStart = (state == ST_SCANOUT) && stepFirst;
  assign scanInStart  = (state == ST_SCANIN)  && stepFirst;
  assign restoreStart = (state == ST_CPURST)  && stepFirst;

endmodule

// File: rtl/stbySeqDatapath.sv
module stbySeqDatapath
  import stbySeqPkg::*;
#(
  parameter int NUM_IP = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              irqWake,
  input  logic              rtcMatch,
  input  logic [CNT_W-1:0]  stepLimit,
  input  logic [NUM_IP-1:0] ipClkMask,
  output logic              stepFirst,
  output logic              timeoutHit,
  output logic              wakePend,
  output logic              deepMode,
  output logic              cpuClkOn,
  output logic              pllOn,
  output logic              pwrOn,
  output logic              isoOn,
  output logic              errFlag,
  output logic [NUM_IP-1:0] ipClkEn
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] stepCnt;
  logic             busClkOn;

  // Step timer: restarts on every state change, saturates
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepCnt <= '0;
    end else if (strobe.cntClr) begin
      stepCnt <= '0;
    end else if (stepCnt != CNT_MAX) begin
      stepCnt <= stepCnt + 1'b1;
    end
  end

  assign stepFirst  = (stepCnt == '0);
  assign timeoutHit = (stepCnt == stepLimit);

  // Wake latch only while an entry step is running
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wakePend <= 1'b0;
    else       wakePend <= strobe.watchWake & (wakePend | irqWake | rtcMatch);
  end

  // Clock controls
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuClkOn <= 1'b1;
      busClkOn <= 1'b1;
      pllOn    <= 1'b1;
    end else begin
      if (strobe.cpuGate) cpuClkOn <= 1'b0;
      if (strobe.clkStop) begin
        cpuClkOn <= 1'b0;
        busClkOn <= 1'b0;
        pllOn    <= 1'b0;
      end
      if (strobe.pllOn) pllOn <= 1'b1;
      if (strobe.cpuUngate || strobe.clkStart) cpuClkOn <= 1'b1;
      if (strobe.clkStart) busClkOn <= 1'b1;
    end
  end

  // Power, isolation, mode and error state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrOn    <= 1'b1;
      isoOn    <= 1'b0;
      deepMode <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      if (strobe.pwrCut)     pwrOn <= 1'b0;
      if (strobe.pwrRestore) pwrOn <= 1'b1;
      if (strobe.isoSet)     isoOn <= 1'b1;
      if (strobe.isoRelease) isoOn <= 1'b0;
      if (strobe.deepSet)    deepMode <= 1'b1;
      if (strobe.deepClr)    deepMode <= 1'b0;
      if (strobe.errSet)     errFlag <= 1'b1;
      if (strobe.errClr)     errFlag <= 1'b0;
    end
  end

  // Per-IP gating: software bit AND shared peripheral clock run
  for (genvar i = 0; i < NUM_IP; i++) begin : g_ipGate
    assign ipClkEn[i] = ipClkMask[i] & busClkOn;
  end

endmodule

// File: rtl/stbyModeSeq.sv
module stbyModeSeq
  import stbySeqPkg::*;
#(
  parameter int NUM_IP = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeGo,
  input  logic [1:0]        modeReq,
  input  logic [NUM_IP-1:0] ipClkMask,
  input  logic              irqWake,
  input  logic              rtcMatch,
  input  logic [CNT_W-1:0]  stepLimit,
  input  logic              errClr,
  input  logic              saveDone,
  input  logic              flushDone,
  input  logic              scanOutDone,
  input  logic              pwrAck,
  input  logic              scanInDone,
  input  logic              clkReady,
  input  logic              restoreDone,
  output logic [NUM_IP-1:0] ipClkEn,
  output logic              cpuClkEn,
  output logic              pllEn,
  output logic              logicPwrEn,
  output logic              isoEn,
  output logic              saveStart,
  output logic              flushStart,
  output logic              scanOutStart,
  output logic              scanInStart,
  output logic              restoreStart,
  output logic [3:0]        seqState,
  output logic              errFlag
);

  seqState_e  state;
  seqStrobe_t strobe;
  logic       stepFirst;
  logic       timeoutHit;
  logic       wakePend;
  logic       deepMode;

  stbySeqCtrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .modeGo       (modeGo),
    .modeReq      (modeReq),
    .irqWake      (irqWake),
    .rtcMatch     (rtcMatch),
    .wakePend     (wakePend),
    .deepMode     (deepMode),
    .stepFirst    (stepFirst),
    .timeoutHit   (timeoutHit),
    .errClr       (errClr),
    .saveDone     (saveDone),
    .flushDone    (flushDone),
    .scanOutDone  (scanOutDone),
    .pwrAck       (pwrAck),
    .scanInDone   (scanInDone),
    .clkReady     (clkReady),
    .restoreDone  (restoreDone),
    .state        (state),
    .strobe       (strobe),
    .saveStart    (saveStart),
    .flushStart   (flushStart),
    .scanOutStart (scanOutStart),
    .scanInStart  (scanInStart),
    .restoreStart (restoreStart)
  );

  stbySeqDatapath #(
    .NUM_IP (NUM_IP),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .irqWake    (irqWake),
    .rtcMatch   (rtcMatch),
    .stepLimit  (stepLimit),
    .ipClkMask  (ipClkMask),
    .stepFirst  (stepFirst),
    .timeoutHit (timeoutHit),
    .wakePend   (wakePend),
    .deepMode   (deepMode),
    .cpuClkOn   (cpuClkEn),
    .pllOn      (pllEn),
    .pwrOn      (logicPwrEn),
    .isoOn      (isoEn),
    .errFlag    (errFlag),
    .ipClkEn    (ipClkEn)
  );

  assign seqState = state;

endmodule

// File: rtl/stbySeqChk.sv
module stbySeqChk #(
  parameter int NUM_IP = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_IP-1:0] ipClkEn,
  input logic              cpuClkEn,
  input logic              pllEn,
  input logic              logicPwrEn,
  input logic              isoEn,
  input logic              saveStart,
  input logic              flushStart,
  input logic              scanOutStart,
  input logic              scanInStart,
  input logic              restoreStart,
  input logic [3:0]        seqState,
  input logic              errFlag
);

  // R11
  pwr_off_iso_chk: assert property (@(posedge clk) disable iff (!rstN)
    !logicPwrEn |-> isoEn);

  // R11
  iso_release_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(isoEn) |-> (cpuClkEn && pllEn));

  // R5
  pwr_off_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    !logicPwrEn |-> (!pllEn && !cpuClkEn && (ipClkEn == '0)));

  // R5
  start_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({saveStart, flushStart, scanOutStart, scanInStart, restoreStart}));

  // R3
  light_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == 4'd1) |-> (!cpuClkEn && pllEn && logicPwrEn));

  // R4
  halt_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == 4'd2) |-> (!pllEn && logicPwrEn && !isoEn));

  // R9
  err_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> (seqState == 4'd15));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(errFlag) |-> ($past(seqState) == 4'd15) && (seqState == 4'd0));

endmodule

bind stbyModeSeq stbySeqChk #(.NUM_IP(NUM_IP)) u_seqChk (
  .clk          (clk),
  .rstN         (rstN),
  .ipClkEn      (ipClkEn),
  .cpuClkEn     (cpuClkEn),
  .pllEn        (pllEn),
  .logicPwrEn   (logicPwrEn),
  .isoEn        (isoEn),
  .saveStart    (saveStart),
  .flushStart   (flushStart),
  .scanOutStart (scanOutStart),
  .scanInStart  (scanInStart),
  .restoreStart (restoreStart),
  .seqState     (seqState),
  .errFlag      (errFlag)
);

// File: tb/tb_stbyModeSeq.sv
module tb_stbyModeSeq;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_IP = 8;
  localparam int CNT_W = 16;
  localparam int NVEC = 5;

  // {mode, restCode, cpu, pll, pwr, iso, ipOn, useRtc}
  localparam logic [11:0] VEC [0:NVEC-1] = '{
    {2'd1, 4'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {2'd2, 4'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {2'd3, 4'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'd3, 4'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {2'd1, 4'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeGo = 1'b0;
  logic [1:0] modeReq = 2'd0;
  logic [NUM_IP-1:0] ipClkMask = 8'hA5;
  logic irqWake = 1'b0;
  logic rtcMatch = 1'b0;
  logic [CNT_W-1:0] stepLimit = 16'd100;
  logic errClr = 1'b0;
  logic saveDone = 1'b0;
  logic flushDone = 1'b0;
  logic scanOutDone = 1'b0;
  logic pwrAck = 1'b0;
  logic scanInDone = 1'b0;
  logic clkReady = 1'b0;
  logic restoreDone = 1'b0;
  logic [NUM_IP-1:0] ipClkEn;
  logic cpuClkEn, pllEn, logicPwrEn, isoEn;
  logic saveStart, flushStart, scanOutStart, scanInStart, restoreStart;
  logic [3:0] seqState;
  logic errFlag;

  int total = 0;
  int bad = 0;
  int isoBad = 0;
  int pwrFalls = 0;
  logic autoAgent = 1'b0;
  logic [4:0] agWhich;
  bit finished = 1'b0;

  stbyModeSeq #(.NUM_IP(NUM_IP), .CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .modeGo(modeGo), .modeReq(modeReq),
    .ipClkMask(ipClkMask), .irqWake(irqWake), .rtcMatch(rtcMatch),
    .stepLimit(stepLimit), .errClr(errClr), .saveDone(saveDone),
    .flushDone(flushDone), .scanOutDone(scanOutDone), .pwrAck(pwrAck),
    .scanInDone(scanInDone), .clkReady(clkReady), .restoreDone(restoreDone),
    .ipClkEn(ipClkEn), .cpuClkEn(cpuClkEn), .pllEn(pllEn),
    .logicPwrEn(logicPwrEn), .isoEn(isoEn), .saveStart(saveStart),
    .flushStart(flushStart), .scanOutStart(scanOutStart),
    .scanInStart(scanInStart), .restoreStart(restoreStart),
    .seqState(seqState), .errFlag(errFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitState(input logic [3:0] code, input string tag);
    int n = 0;
    while (seqState !== code && n < 300) begin
      @(negedge clk);
      n++;
    end
    check(tag, {28'd0, seqState}, {28'd0, code});
  endtask

  task automatic goMode(input logic [1:0] m);
    modeReq = m;
    modeGo = 1'b1;
    @(negedge clk);
    modeGo = 1'b0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Handshake agent: answers a start pulse after three cycles
  initial begin
    forever begin
      if (autoAgent === 1'b1 &&
          (saveStart | flushStart | scanOutStart | scanInStart | restoreStart) === 1'b1) begin
        agWhich = {saveStart, flushStart, scanOutStart, scanInStart, restoreStart};
        repeat (3) @(negedge clk);
        {saveDone, flushDone, scanOutDone, scanInDone, restoreDone} = agWhich;
        @(negedge clk);
        {saveDone, flushDone, scanOutDone, scanInDone, restoreDone} = 5'd0;
      end else begin
        @(negedge clk);
      end
    end
  end

  // Power switch and clock source follow their enables after three cycles
  initial begin
    int pd;
    int cd;
    pd = 0;
    cd = 0;
    forever begin
      @(negedge clk);
      if (pwrAck !== logicPwrEn) begin
        pd++;
        if (pd >= 3) begin pwrAck = logicPwrEn; pd = 0; end
      end else pd = 0;
      if (clkReady !== pllEn) begin
        cd++;
        if (cd >= 3) begin clkReady = pllEn; cd = 0; end
      end else cd = 0;
    end
  end

  // Isolation monitor (R11) and power-removal counter
  initial begin
    logic prevIso;
    logic prevPwr;
    prevIso = 1'b0;
    prevPwr = 1'b1;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (!logicPwrEn && !isoEn) isoBad++;
        if (prevIso && !isoEn && !(cpuClkEn && pllEn)) isoBad++;
        if (prevPwr && !logicPwrEn) pwrFalls++;
        prevIso = isoEn;
        prevPwr = logicPwrEn;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (50000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    finishRun();
  end

  initial begin
    int fallsBefore;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset state
    check("R1 state", {28'd0, seqState}, 32'd0);
    check("R1 clocks", {29'd0, cpuClkEn, pllEn, logicPwrEn}, 32'd7);
    check("R1 iso/err", {30'd0, isoEn, errFlag}, 32'd0);
    check("R1 starts", {27'd0, saveStart, flushStart, scanOutStart, scanInStart, restoreStart}, 32'd0);
    check("R2 mask at reset", {24'd0, ipClkEn}, 32'hA5);

    // R2 mask follows combinationally
    ipClkMask = 8'h3C;
    #1;
    check("R2 mask change", {24'd0, ipClkEn}, 32'h3C);
    ipClkMask = 8'hA5;

    // R12 mode code 0 ignored
    goMode(2'd0);
    repeat (3) @(negedge clk);
    check("R12 stays run", {28'd0, seqState}, 32'd0);
    check("R12 outputs", {28'd0, cpuClkEn, pllEn, logicPwrEn, isoEn}, 32'hE);

    // R7 wake in run is not remembered
    irqWake = 1'b1;
    @(negedge clk);
    irqWake = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 run wake ignored", {28'd0, seqState}, 32'd0);
    goMode(2'd1);
    waitState(4'd1, "R3 enter light");
    repeat (3) @(negedge clk);
    check("R7 no stale wake", {28'd0, seqState}, 32'd1);
    rtcMatch = 1'b1;
    @(negedge clk);
    rtcMatch = 1'b0;
    waitState(4'd0, "R7 timer wake");

    // Table walk with automatic agents
    autoAgent = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      logic [11:0] v;
      v = VEC[i];
      goMode(v[11:10]);
      waitState(v[9:6], "R3 R4 R5 rest code");
      check("R3 R4 R5 rest outputs", {28'd0, cpuClkEn, pllEn, logicPwrEn, isoEn}, {28'd0, v[5:2]});
      check("R2 ip enables at rest", {24'd0, ipClkEn}, v[1] ? 32'hA5 : 32'h0);
      repeat (5) @(negedge clk);
      if (v[0]) rtcMatch = 1'b1; else irqWake = 1'b1;
      @(negedge clk);
      rtcMatch = 1'b0;
      irqWake = 1'b0;
      if (v[11:10] >= 2'd2) begin
        waitState(4'd10, "R4 R6 clock restart");
        check("R4 R6 pll before cpu", {30'd0, pllEn, cpuClkEn}, 32'd2);
      end
      waitState(4'd0, "R7 wake back to run");
      check("R3 R4 R6 all on", {28'd0, cpuClkEn, pllEn, logicPwrEn, isoEn}, 32'hE);
      check("R2 ip restored", {24'd0, ipClkEn}, 32'hA5);
    end
    autoAgent = 1'b0;
    repeat (6) @(negedge clk);

    // R5 / R6 deep sequence driven by hand
    goMode(2'd3);
    waitState(4'd4, "R5 save step");
    check("R5 save start", {31'd0, saveStart}, 32'd1);
    saveDone = 1'b1; @(negedge clk); saveDone = 1'b0;
    waitState(4'd5, "R5 flush step");
    check("R5 flush start, clocks on", {29'd0, flushStart, pllEn, isoEn}, 32'd6);
    flushDone = 1'b1; @(negedge clk); flushDone = 1'b0;
    waitState(4'd6, "R5 scan-out step");
    check("R5 scan-out outputs", {27'd0, scanOutStart, cpuClkEn, pllEn, isoEn, logicPwrEn}, 32'h13);
    check("R5 ip off", {24'd0, ipClkEn}, 32'd0);
    scanOutDone = 1'b1; @(negedge clk); scanOutDone = 1'b0;
    waitState(4'd7, "R5 power-off step");
    check("R5 power removed", {31'd0, logicPwrEn}, 32'd0);
    waitState(4'd3, "R5 suspended");
    irqWake = 1'b1; @(negedge clk); irqWake = 1'b0;
    waitState(4'd8, "R6 power-on step");
    check("R6 power on, iso held", {30'd0, logicPwrEn, isoEn}, 32'd3);
    waitState(4'd9, "R6 scan-in step");
    check("R6 scan-in start", {31'd0, scanInStart}, 32'd1);
    scanInDone = 1'b1; @(negedge clk); scanInDone = 1'b0;
    waitState(4'd10, "R6 clock step");
    check("R6 pll on, cpu off", {29'd0, pllEn, cpuClkEn, isoEn}, 32'd5);
    waitState(4'd11, "R6 restore step");
    check("R6 restore outputs", {29'd0, restoreStart, cpuClkEn, isoEn}, 32'd6);
    restoreDone = 1'b1; @(negedge clk); restoreDone = 1'b0;
    waitState(4'd0, "R6 back to run");

    // R8 wake during save
    repeat (6) @(negedge clk);
    fallsBefore = pwrFalls;
    goMode(2'd3);
    waitState(4'd4, "R8 save step");
    irqWake = 1'b1; @(negedge clk); irqWake = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 step completes first", {28'd0, seqState}, 32'd4);
    saveDone = 1'b1; @(negedge clk); saveDone = 1'b0;
    waitState(4'd11, "R8 save to restore");
    check("R8 outputs kept", {28'd0, restoreStart, pllEn, logicPwrEn, isoEn}, 32'hE);
    restoreDone = 1'b1; @(negedge clk); restoreDone = 1'b0;
    waitState(4'd0, "R8 run after early wake");

    // R8 wake during scan-out
    repeat (6) @(negedge clk);
    goMode(2'd3);
    waitState(4'd4, "R8 save step b");
    saveDone = 1'b1; @(negedge clk); saveDone = 1'b0;
    waitState(4'd5, "R8 flush step b");
    flushDone = 1'b1; @(negedge clk); flushDone = 1'b0;
    waitState(4'd6, "R8 scan-out step b");
    rtcMatch = 1'b1; @(negedge clk); rtcMatch = 1'b0;
    repeat (2) @(negedge clk);
    scanOutDone = 1'b1; @(negedge clk); scanOutDone = 1'b0;
    waitState(4'd10, "R8 scan-out to clock step");
    check("R8 power kept, iso on", {29'd0, logicPwrEn, isoEn, pllEn}, 32'd7);
    waitState(4'd11, "R8 restore after clocks");
    check("R8 iso released", {30'd0, cpuClkEn, isoEn}, 32'd2);
    restoreDone = 1'b1; @(negedge clk); restoreDone = 1'b0;
    waitState(4'd0, "R8 run b");
    check("R8 power never removed", pwrFalls, fallsBefore);

    // R9 timeout in flush step, R10 sticky flag
    repeat (6) @(negedge clk);
    stepLimit = 16'd5;
    goMode(2'd3);
    waitState(4'd4, "R9 save step");
    saveDone = 1'b1; @(negedge clk); saveDone = 1'b0;
    waitState(4'd5, "R9 flush step");
    repeat (5) @(negedge clk);
    check("R9 still waiting at limit", {28'd0, seqState}, 32'd5);
    @(negedge clk);
    check("R9 error state", {28'd0, seqState}, 32'd15);
    check("R9 flag and held outputs", {28'd0, errFlag, cpuClkEn, pllEn, logicPwrEn}, 32'hF);
    repeat (4) @(negedge clk);
    check("R10 flag sticky", {27'd0, errFlag, seqState}, 32'h1F);
    errClr = 1'b1; @(negedge clk); errClr = 1'b0;
    check("R10 cleared to run", {27'd0, errFlag, seqState}, 32'd0);
    check("R10 all on", {28'd0, cpuClkEn, pllEn, logicPwrEn, isoEn}, 32'hE);
    stepLimit = 16'd100;

    repeat (4) @(negedge clk);
    check("R11 isolation monitor", isoBad, 0);
    finishRun();
  end

endmodule